// File: doc/BRIEF.md
# I2C Controller Interrupt Status Unit

This block sits next to the bit engine of an I2C master/slave controller. It collects event pulses from that engine and turns them into sticky status flags with a combined interrupt request. It tracks three kinds of condition. The first is a lost arbitration while acting as master. The second is a STOP or repeated START seen while addressed as a slave. The third is a not-acknowledge, which has different rules in master mode and in slave mode.

The arbitration and stop/restart flags clear when software reads the status. The not-acknowledge flag clears in a way that depends on the mode. A slave-mode NACK clears on a status read. A master-mode NACK stays set until the START or STOP control bit is set. Until then the unit holds a stall line that freezes further master bus activity. A lost arbitration also produces a one-cycle request that sends the controller back to slave mode. A separate indicator records whether the most recent stop/restart flag came from a STOP or from a RESTART.

The not-acknowledge flag is kept by a small state machine. Its states are `NK_CLEAR` (no flag), `NK_MST_HOLD` (master NACK, stalled) and `NK_SLV_FLAG` (slave NACK). Its transitions are:
- *master-nack-raise*: from `NK_CLEAR` or `NK_SLV_FLAG` to `NK_MST_HOLD`.
- *slave-nack-raise*: from `NK_CLEAR` to `NK_SLV_FLAG`.
- *start-stop-release*: from `NK_MST_HOLD` to `NK_CLEAR`.
- *read-release*: from `NK_SLV_FLAG` to `NK_CLEAR`.

Top module: `i2cint_top`

## Requirements
- R1: An `ev_arb_lost` pulse while `is_master`=1 sets `st_arb` at the next clock edge, and `force_slave` is high for exactly that one cycle. In slave mode the pulse is ignored.
- R2: `st_arb` stays set until a cycle with `stat_rd`=1. It is low after the edge that ends that cycle.
- R3: `st_spr` is set only by `ev_stop` or `ev_restart` in a cycle where `is_master`=0 and `addressed`=1. In any other cycle these pulses are ignored.
- R4: When `st_spr` is set, `spr_restart` takes 1 for a restart and 0 for a stop. A restart wins if both arrive together. The value is held until the next setting event.
- R5: `st_spr` clears at the edge ending a cycle with `stat_rd`=1.
- R6: `ev_mst_nack` with `is_master`=1, `ctl_start`=0 and `ctl_stop`=0 sets `st_nck` and `master_hold`. A status read does not clear them. Both fall at the edge ending the first cycle with `ctl_start` or `ctl_stop` high.
- R7: `ev_slv_nack` with `is_master`=0 sets `st_nck` without `master_hold`, and a status read clears it. A master NACK arriving while a slave NACK is flagged converts the flag to the master kind. A slave NACK arriving while a master NACK is flagged is ignored.
- R8: With `IRQ_PIPE`=1, `irq` equals `irq_en` AND (`st_arb` OR `st_spr` OR `st_nck`), registered one cycle. With `IRQ_PIPE`=0 it is the same expression, combinational.
- R9: A setting event in the same cycle as a status read wins, and the flag stays set.
- R10: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_en | input | 1 | Global interrupt enable |
| is_master | input | 1 | 1 = controller currently master |
| ctl_start | input | 1 | START control bit |
| ctl_stop | input | 1 | STOP control bit |
| addressed | input | 1 | Slave selected by address match |
| stat_rd | input | 1 | Status register read strobe |
| ev_arb_lost | input | 1 | Drove 1, sampled 0 on SDA |
| ev_stop | input | 1 | STOP condition received |
| ev_restart | input | 1 | Repeated START received |
| ev_mst_nack | input | 1 | NACK sent or received in master mode |
| ev_slv_nack | input | 1 | NACK received after transmitted data in slave mode |
| st_arb | output | 1 | Arbitration-lost flag |
| st_spr | output | 1 | Stop/restart flag |
| st_nck | output | 1 | Not-acknowledge flag |
| spr_restart | output | 1 | 1 = last stop/restart flag came from a restart |
| force_slave | output | 1 | One-cycle request to drop to slave mode |
| master_hold | output | 1 | Master bus activity stalled |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the unit with `IRQ_PIPE`=1. That setting brings the one-cycle lag between a flag change and the interrupt line into reach of every check, and the bench's reference model predicts the registered value. Random mode, address and event mixes drive the not-acknowledge state machine through all four of its transitions. They also reach the state where a slave NACK is overtaken by a master NACK. Directed sequences add the read-versus-event races, a status read while the master is stalled, and simultaneous stop and restart pulses.

// File: rtl/i2cint_pkg.sv
package i2cint_pkg;
    typedef enum logic [1:0] {
        NK_CLEAR    = 2'd0,
        NK_MST_HOLD = 2'd1,
        NK_SLV_FLAG = 2'd2
    } nack_state_e;

    localparam int FLG_ARB = 0;
    localparam int FLG_SPR = 1;
    localparam int NUM_RC  = 2;
endpackage

// File: rtl/i2cint_rcflag.sv
module i2cint_rcflag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_i,
    output logic q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;   // event beats read
        else if (rd_i)  q_o <= 1'b0;
    end
endmodule

// File: rtl/i2cint_nack_fsm.sv
module i2cint_nack_fsm
    import i2cint_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mst_raise_i,
    input  logic slv_raise_i,
    input  logic release_i,
    input  logic rd_i,
    output logic flag_o,
    output logic hold_o
);
    nack_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= NK_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NK_CLEAR: begin
                if (mst_raise_i)      state_d = NK_MST_HOLD;
                else if (slv_raise_i) state_d = NK_SLV_FLAG;
            end
            NK_MST_HOLD: begin
                if (release_i)        state_d = NK_CLEAR;
            end
            NK_SLV_FLAG: begin
                if (mst_raise_i)      state_d = NK_MST_HOLD;
                else if (slv_raise_i) state_d = NK_SLV_FLAG;
                else if (rd_i)        state_d = NK_CLEAR;
            end
            default:                  state_d = NK_CLEAR;
        endcase
    end

    always_comb begin
        flag_o = 1'b0;
        hold_o = 1'b0;
        unique case (state_q)
            NK_CLEAR:    ;
            NK_MST_HOLD: begin flag_o = 1'b1; hold_o = 1'b1; end
            NK_SLV_FLAG: flag_o = 1'b1;
            default:     ;
        endcase
    end
endmodule

// File: rtl/i2cint_top.sv
module i2cint_top
    import i2cint_pkg::*;
#(
    parameter bit IRQ_PIPE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_en,
    input  logic is_master,
    input  logic ctl_start,
    input  logic ctl_stop,
    input  logic addressed,
    input  logic stat_rd,
    input  logic ev_arb_lost,
    input  logic ev_stop,
    input  logic ev_restart,
    input  logic ev_mst_nack,
    input  logic ev_slv_nack,
    output logic st_arb,
    output logic st_spr,
    output logic st_nck,
    output logic spr_restart,
    output logic force_slave,
    output logic master_hold,
    output logic irq
);
    logic [NUM_RC-1:0] rc_set;
    logic [NUM_RC-1:0] rc_q;
    logic              any_flag;

    assign rc_set[FLG_ARB] = ev_arb_lost & is_master;
    assign rc_set[FLG_SPR] = ~is_master & addressed & (ev_stop | ev_restart);

    for (genvar gi = 0; gi < NUM_RC; gi++) begin : g_rc
        i2cint_rcflag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (rc_set[gi]),
            .rd_i  (stat_rd),
            .q_o   (rc_q[gi])
        );
    end

    assign st_arb = rc_q[FLG_ARB];
    assign st_spr = rc_q[FLG_SPR];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spr_restart <= 1'b0;
            force_slave <= 1'b0;
        end else begin
            force_slave <= rc_set[FLG_ARB];
            if (rc_set[FLG_SPR]) spr_restart <= ev_restart;
        end
    end

    i2cint_nack_fsm u_nack (
        .clk         (clk),
        .rst_n       (rst_n),
        .mst_raise_i (is_master & ev_mst_nack & ~ctl_start & ~ctl_stop),
        .slv_raise_i (~is_master & ev_slv_nack),
        .release_i   (ctl_start | ctl_stop),
        .rd_i        (stat_rd),
        .flag_o      (st_nck),
        .hold_o      (master_hold)
    );

    assign any_flag = st_arb | st_spr | st_nck;

    if (IRQ_PIPE) begin : g_irq_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= irq_en & any_flag;
        end
    end else begin : g_irq_comb
        assign irq = irq_en & any_flag;
    end
endmodule

// File: rtl/i2cint_checker.sv
module i2cint_checker #(
    parameter bit IRQ_PIPE = 1'b1
) (
    input logic clk,
    input logic rst_n,
    input logic irq_en,
    input logic is_master,
    input logic ctl_start,
    input logic ctl_stop,
    input logic addressed,
    input logic stat_rd,
    input logic ev_arb_lost,
    input logic ev_stop,
    input logic ev_restart,
    input logic ev_mst_nack,
    input logic ev_slv_nack,
    input logic st_arb,
    input logic st_spr,
    input logic st_nck,
    input logic spr_restart,
    input logic force_slave,
    input logic master_hold,
    input logic irq
);
    p_arb_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_arb_lost && is_master) |=> (st_arb && force_slave));

    p_arb_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_arb && !stat_rd) |=> st_arb);

    p_spr_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_spr && !(addressed && !is_master && (ev_stop || ev_restart))) |=> !st_spr);

    p_rst_kind_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_master && addressed && ev_restart) |=> spr_restart);

    p_hold_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (master_hold && !ctl_start && !ctl_stop) |=> master_hold);

    p_hold_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (master_hold && (ctl_start || ctl_stop)) |=> (!master_hold && !st_nck));

    p_slv_nack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_master && ev_slv_nack && !master_hold) |=> (st_nck && !master_hold));

    p_race_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !is_master && addressed && ev_stop) |=> st_spr);

    if (IRQ_PIPE) begin : g_pipe
        p_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_en && (st_arb || st_spr || st_nck)) |=> irq);
        p_irq_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !irq_en |=> !irq);
    end else begin : g_comb
        p_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
            irq |-> (irq_en && (st_arb || st_spr || st_nck)));
    end
endmodule

bind i2cint_top i2cint_checker #(.IRQ_PIPE(IRQ_PIPE)) u_checker (.*);

// File: tb/i2cint_top_bench.sv
`timescale 1ns/1ps
module i2cint_top_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic irq_en = 0, is_master = 0, ctl_start = 0, ctl_stop = 0, addressed = 0, stat_rd = 0;
    logic ev_arb_lost = 0, ev_stop = 0, ev_restart = 0, ev_mst_nack = 0, ev_slv_nack = 0;
    logic st_arb, st_spr, st_nck, spr_restart, force_slave, master_hold, irq;

    int total = 0;
    int bad = 0;

    // reference model state
    logic e_arb = 0, e_spr = 0, e_rst = 0, e_fs = 0, e_irq = 0;
    int   e_nk = 0; // 0 clear, 1 master hold, 2 slave flag

    always #2.5 clk = ~clk;

    i2cint_top #(.IRQ_PIPE(1'b1)) u_i2cint_top (.*);

    task automatic chk(input logic act, input logic exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic nk_flag(input int s);
        return s != 0;
    endfunction

    task automatic model_edge();
        logic arb_ev, spr_ev, mn, sn;
        e_irq  = irq_en & (e_arb | e_spr | nk_flag(e_nk));
        arb_ev = ev_arb_lost & is_master;
        spr_ev = !is_master & addressed & (ev_stop | ev_restart);
        mn     = is_master & ev_mst_nack & !ctl_start & !ctl_stop;
        sn     = !is_master & ev_slv_nack;
        e_fs   = arb_ev;
        e_arb  = arb_ev ? 1'b1 : (stat_rd ? 1'b0 : e_arb);
        e_spr  = spr_ev ? 1'b1 : (stat_rd ? 1'b0 : e_spr);
        if (spr_ev) e_rst = ev_restart;
        case (e_nk)
            0: if (mn) e_nk = 1; else if (sn) e_nk = 2;
            1: if (ctl_start | ctl_stop) e_nk = 0;
            default: if (mn) e_nk = 1; else if (sn) e_nk = 2; else if (stat_rd) e_nk = 0;
        endcase
    endtask

    task automatic check_all();
        chk(st_arb, e_arb, "R1/R2 st_arb");
        chk(force_slave, e_fs, "R1 force_slave");
        chk(st_spr, e_spr, "R3/R5 st_spr");
        chk(spr_restart, e_rst, "R4 spr_restart");
        chk(st_nck, nk_flag(e_nk), "R6/R7 st_nck");
        chk(master_hold, e_nk == 1, "R6 master_hold");
        chk(irq, e_irq, "R8 irq");
    endtask

    // inputs were set at the negedge; model and compare just after the edge
    task automatic step();
        @(posedge clk);
        model_edge();
        #1;
        check_all();
        @(negedge clk);
        {ev_arb_lost, ev_stop, ev_restart, ev_mst_nack, ev_slv_nack, stat_rd, ctl_start, ctl_stop} = '0;
    endtask

    initial begin : watchdog
        #1000000;
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(st_arb | st_spr | st_nck | spr_restart | force_slave | master_hold | irq, 1'b0, "R10 reset");
        rst_n = 1'b1;
        irq_en = 1'b1;

        // R1: arbitration event ignored in slave mode
        is_master = 0; ev_arb_lost = 1; step();
        chk(st_arb, 1'b0, "R1 slave ignore");
        // R1/R2 master arbitration lost, then read clears
        is_master = 1; ev_arb_lost = 1; step();
        chk(force_slave, 1'b1, "R1 pulse");
        step(); chk(force_slave, 1'b0, "R1 pulse one cycle");
        stat_rd = 1; step(); chk(st_arb, 1'b0, "R2 read clear");

        // R3: unaddressed stop ignored
        is_master = 0; addressed = 0; ev_stop = 1; step();
        chk(st_spr, 1'b0, "R3 unaddressed");
        // R4 both -> restart wins; R9 race with read
        addressed = 1; ev_stop = 1; ev_restart = 1; stat_rd = 1; step();
        chk(st_spr, 1'b1, "R9 event beats read");
        chk(spr_restart, 1'b1, "R4 restart wins");
        stat_rd = 1; step(); chk(st_spr, 1'b0, "R5 read clear");
        chk(spr_restart, 1'b1, "R4 held");
        ev_stop = 1; step(); chk(spr_restart, 1'b0, "R4 stop kind");
        stat_rd = 1; step();

        // R6: master nack, read does not clear, start releases
        is_master = 1; ev_mst_nack = 1; step();
        chk(master_hold, 1'b1, "R6 hold");
        stat_rd = 1; step(); chk(st_nck, 1'b1, "R6 read no clear");
        ctl_stop = 1; step(); chk(master_hold, 1'b0, "R6 release");
        ev_mst_nack = 1; ctl_start = 1; step(); chk(st_nck, 1'b0, "R6 masked by START");

        // R7: slave nack, then read clears
        is_master = 0; ev_slv_nack = 1; step();
        chk(st_nck & ~master_hold, 1'b1, "R7 slave flag");
        stat_rd = 1; step(); chk(st_nck, 1'b0, "R7 read clear");

        // R8: enable gating
        irq_en = 0; is_master = 1; ev_arb_lost = 1; step(); step();
        chk(irq, 1'b0, "R8 gated");
        irq_en = 1; step(); step();
        chk(irq, 1'b1, "R8 enabled");
        stat_rd = 1; step();

        // random mix
        for (int i = 0; i < 4000; i++) begin
            irq_en      = ($urandom % 4) != 0;
            if (($urandom % 8) == 0) is_master = ~is_master;
            addressed   = $urandom % 2;
            ev_arb_lost = ($urandom % 6) == 0;
            ev_stop     = ($urandom % 6) == 0;
            ev_restart  = ($urandom % 6) == 0;
            ev_mst_nack = ($urandom % 5) == 0;
            ev_slv_nack = ($urandom % 5) == 0;
            stat_rd     = ($urandom % 4) == 0;
            ctl_start   = ($urandom % 10) == 0;
            ctl_stop    = ($urandom % 10) == 0;
            step();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule